// File: doc/BRIEF.md
# Atomic Bit Fill and Drain Server

This block sits next to memory and owns a single 512-bit line that holds a slot bitmap for a lockless multi-producer, multi-consumer channel. Requesters never fetch the line. They send an operation and a limit, and the server decides which bits to flip. A fill turns up to a requested number of clear slots into set ones. A drain does the reverse. The server answers with the mask of bits that actually changed, so a requester claims slots without ever knowing the bitmap beforehand. An all-zero answer means nothing was available.

The low 480 bits are the slot bitmap. The top 32 bits form a control word, in which line bit 480 (word bit 0) is a sleeping flag and line bit 481 (word bit 1) is a dead flag. Requesters can also publish slots with mask updates: an OR form sets bits and an AND-with-inverted-mask form clears them. Either form can raise the sleeping flag in the same step. The control word has its own OR, clear and read operations, so software can use it as a wait word.

Requests arrive over a valid/ready channel. Each accepted request produces one registered response one cycle later. Requests execute strictly in order, one per cycle.

Top module: `afd_unit`

## Requirements
- R1: After synchronous reset the bitmap and the control word are all zero, resp_valid is low and req_ready is high.
- R2: Opcode 0 (fill) with limit M sets the lowest-indexed clear bitmap bits, at most M of them. resp_mask has exactly those bits set.
- R3: Opcode 1 (drain) with limit M clears the lowest-indexed set bitmap bits, at most M of them. resp_mask has exactly those bits set.
- R4: A fill on a full bitmap, or a drain on an empty one, returns an all-zero resp_mask and changes nothing.
- R5: A limit of zero returns an empty mask and changes nothing. A limit above 480 acts as 480.
- R6: Fill and drain never alter the control word.
- R7: Opcode 2 (OR update) sets the bitmap bits in req_mask. resp_mask holds the bits that went from 0 to 1. When req_sleep is 1, control word bit 0 (sleeping) is set in the same step. resp_word returns the control word as it was before the request.
- R8: Opcode 3 (AND update) clears the bitmap bits in req_mask. resp_mask holds the bits that went from 1 to 0. The req_sleep and resp_word behaviour is the same as in R7.
- R9: Every response carries in resp_dead the value of control word bit 1 (dead) as it was when the request executed.
- R10: Opcode 4 ORs req_word into the control word, and opcode 5 clears the control word bits set in req_word. Opcodes 6 and 7 only read. All four return the prior word in resp_word with an all-zero resp_mask.
- R11: Every accepted request gives exactly one response on the next cycle. A request accepted right after another one sees the state that the earlier request left.
- R12: While resp_valid is high and resp_ready is low, the response stays stable and req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Operation code |
| req_count | input | 9 | Maximum bits to flip for fill and drain |
| req_mask | input | 480 | Bitmap mask for OR and AND updates |
| req_word | input | 32 | Operand for control word operations |
| req_sleep | input | 1 | Raise the sleeping flag along with a mask update |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken this cycle |
| resp_mask | output | 480 | Bitmap bits changed by the request |
| resp_word | output | 32 | Control word before the request |
| resp_dead | output | 1 | Dead flag at execution |

## Verification
The overlap of interest is a bitmap update and a fill or drain arriving in back-to-back cycles. The second operation must pick its bits from the state the first one left, not from a stale copy. The bench issues runs of requests with no idle cycle between them, mixing mask updates, fills, drains and control word writes, and sometimes withholds resp_ready so that new requests are stalled while a response is held. A behavioural model updates its own bitmap in request order, and every cycle the handshake signals and the held response are compared against it.

// File: rtl/afd_pkg.sv
package afd_pkg;
    localparam int LINE_W = 512;
    localparam int CTRL_W = 32;

    typedef enum logic [2:0] {
        OP_FILL   = 3'd0,
        OP_DRAIN  = 3'd1,
        OP_OR     = 3'd2,
        OP_AND    = 3'd3,
        OP_CW_OR  = 3'd4,
        OP_CW_CLR = 3'd5,
        OP_CW_RD  = 3'd6,
        OP_CW_RD2 = 3'd7
    } afd_op_e;

    // layout of the control word at the top of the line
    typedef struct packed {
        logic [CTRL_W-3:0] spare;
        logic              dead;
        logic              sleep;
    } ctrl_word_t;

    function automatic logic is_pick_op(afd_op_e op);
        return (op == OP_FILL) || (op == OP_DRAIN);
    endfunction

    function automatic logic is_mask_op(afd_op_e op);
        return (op == OP_OR) || (op == OP_AND);
    endfunction
endpackage

// File: rtl/afd_seg_pick.sv
module afd_seg_pick #(
    parameter int SEG_W = 32,
    parameter int CNT_W = 9
) (
    input  logic [SEG_W-1:0] cand,
    input  logic [CNT_W-1:0] budget,
    output logic [SEG_W-1:0] pick
);
    // take candidates lowest index first until the budget is spent
    always_comb begin
        logic [CNT_W-1:0] used;
        used = '0;
        pick = '0;
        for (int i = 0; i < SEG_W; i++) begin
            if (cand[i] && (used < budget)) begin
                pick[i] = 1'b1;
                used    = used + 1'b1;
            end
        end
    end
endmodule

// File: rtl/afd_picker.sv
module afd_picker #(
    parameter int DATA_W = 480,
    parameter int SEG_W  = 32,
    parameter int CNT_W  = 9
) (
    input  logic [DATA_W-1:0] cand,
    input  logic [CNT_W-1:0]  limit,
    output logic [DATA_W-1:0] pick
);
    localparam int NSEG = DATA_W / SEG_W;

    logic [CNT_W-1:0] seg_cnt [NSEG];
    logic [CNT_W-1:0] budget  [NSEG];

    // population of each segment
    for (genvar s = 0; s < NSEG; s++) begin : g_cnt
        assign seg_cnt[s] = CNT_W'($countones(cand[s*SEG_W +: SEG_W]));
    end

    // what is left of the limit when each segment is reached
    always_comb begin
        logic [CNT_W-1:0] below;
        below = '0;
        for (int s = 0; s < NSEG; s++) begin
            budget[s] = (below >= limit) ? '0 : (limit - below);
            below     = below + seg_cnt[s];
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        afd_seg_pick #(
            .SEG_W (SEG_W),
            .CNT_W (CNT_W)
        ) i_seg (
            .cand   (cand[s*SEG_W +: SEG_W]),
            .budget (budget[s]),
            .pick   (pick[s*SEG_W +: SEG_W])
        );
    end
endmodule

// File: rtl/afd_ctrl_word.sv
module afd_ctrl_word
    import afd_pkg::*;
(
    input  afd_op_e           op,
    input  logic [CTRL_W-1:0] operand,
    input  logic              set_sleep,
    input  logic [CTRL_W-1:0] cur,
    output logic [CTRL_W-1:0] nxt
);
    ctrl_word_t w;

    always_comb begin
        w = ctrl_word_t'(cur);
        unique case (op)
            OP_OR, OP_AND: if (set_sleep) w.sleep = 1'b1;
            OP_CW_OR:      w = ctrl_word_t'(cur | operand);
            OP_CW_CLR:     w = ctrl_word_t'(cur & ~operand);
            default:       w = ctrl_word_t'(cur);
        endcase
        nxt = w;
    end
endmodule

// File: rtl/afd_unit.sv
module afd_unit
    import afd_pkg::*;
#(
    parameter int SEG_W = 32,
    localparam int DATA_W = LINE_W - CTRL_W,
    localparam int CNT_W  = $clog2(LINE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [DATA_W-1:0] req_mask,
    input  logic [CTRL_W-1:0] req_word,
    input  logic              req_sleep,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [DATA_W-1:0] resp_mask,
    output logic [CTRL_W-1:0] resp_word,
    output logic              resp_dead
);
    afd_op_e           op;
    logic              accept;
    logic [DATA_W-1:0] data_q, data_nxt, cand, pick, changed;
    logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
    ctrl_word_t        ctrl_view;

    assign op        = afd_op_e'(req_op);
    assign req_ready = !resp_valid || resp_ready;
    assign accept    = req_valid && req_ready;
    assign ctrl_view = ctrl_word_t'(ctrl_q);

    // fill hunts for zeros, drain for ones
    assign cand = (op == OP_DRAIN) ? data_q : ~data_q;

    afd_picker #(
        .DATA_W (DATA_W),
        .SEG_W  (SEG_W),
        .CNT_W  (CNT_W)
    ) i_picker (
        .cand  (cand),
        .limit (is_pick_op(op) ? req_count : '0),
        .pick  (pick)
    );

    afd_ctrl_word i_ctrl (
        .op        (op),
        .operand   (req_word),
        .set_sleep (req_sleep),
        .cur       (ctrl_q),
        .nxt       (ctrl_nxt)
    );

    always_comb begin
        data_nxt = data_q;
        changed  = '0;
        unique case (op)
            OP_FILL: begin
                changed  = pick;
                data_nxt = data_q | pick;
            end
            OP_DRAIN: begin
                changed  = pick;
                data_nxt = data_q & ~pick;
            end
            OP_OR: begin
                changed  = req_mask & ~data_q;
                data_nxt = data_q | req_mask;
            end
            OP_AND: begin
                changed  = req_mask & data_q;
                data_nxt = data_q & ~req_mask;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= '0;
            ctrl_q     <= '0;
            resp_valid <= 1'b0;
            resp_mask  <= '0;
            resp_word  <= '0;
            resp_dead  <= 1'b0;
        end else begin
            if (accept) begin
                data_q    <= data_nxt;
                ctrl_q    <= ctrl_nxt;
                resp_mask <= changed;
                resp_word <= ctrl_q;
                resp_dead <= ctrl_view.dead;
            end
            resp_valid <= accept || (resp_valid && !resp_ready);
        end
    end

    // R2
    fill_sets_chk: assert property (@(posedge clk) disable iff (rst)
        accept && op == OP_FILL |=> (data_q & resp_mask) == resp_mask);
    // R3
    drain_clears_chk: assert property (@(posedge clk) disable iff (rst)
        accept && op == OP_DRAIN |=> (data_q & resp_mask) == '0);
    // R5
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        accept && is_pick_op(op) |=> $countones(resp_mask) <= int'($past(req_count)));
    // R6
    ctrl_kept_chk: assert property (@(posedge clk) disable iff (rst)
        accept && is_pick_op(op) |=> ctrl_q == $past(ctrl_q));
    // R11
    one_resp_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> resp_valid);
    // R12
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_mask) && $stable(resp_word));
endmodule

// File: tb/test_afd_unit.sv
module test_afd_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [8:0] req_count = '0;
    logic [479:0] req_mask = '0;
    logic [31:0] req_word = '0;
    logic req_sleep = 1'b0;
    logic resp_valid;
    logic resp_ready = 1'b1;
    logic [479:0] resp_mask;
    logic [31:0] resp_word;
    logic resp_dead;

    always #2 clk = ~clk;

    afd_unit i_afd_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_count(req_count), .req_mask(req_mask),
        .req_word(req_word), .req_sleep(req_sleep), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_mask(resp_mask), .resp_word(resp_word),
        .resp_dead(resp_dead)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    bit [479:0] md = '0;
    bit [31:0]  mc = '0;
    bit         mrv = 0;
    bit [479:0] mm = '0;
    bit [31:0]  mw = '0;
    bit         mdead = 0;
    string      mtag = "R1";
    bit         cur_rr = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [479:0] act, input logic [479:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(req_ready === (!mrv || cur_rr), "R12", "req_ready", 480'(req_ready), 480'(!mrv || cur_rr));
        chk(resp_valid === mrv, "R11", "resp_valid", 480'(resp_valid), 480'(mrv));
        if (mrv) begin
            chk(resp_mask === mm, mtag, "resp_mask", resp_mask, mm);
            chk(resp_word === mw, mtag, "resp_word", 480'(resp_word), 480'(mw));
            chk(resp_dead === mdead, "R9", "resp_dead", 480'(resp_dead), 480'(mdead));
        end
    endtask

    task automatic step(input bit v, input int op, input int cnt, input bit [479:0] msk,
                        input bit [31:0] w, input bit slp, input bit rr, input string tag);
        bit acc;
        bit [479:0] nm;
        bit [31:0] prev;
        int k;
        @(negedge clk);
        compare();
        req_valid  = v;
        req_op     = 3'(op);
        req_count  = 9'(cnt);
        req_mask   = msk;
        req_word   = w;
        req_sleep  = slp;
        resp_ready = rr;
        acc = v && (!mrv || rr);
        if (acc) begin
            prev = mc;
            nm = '0;
            k = 0;
            case (op)
                0: for (int i = 0; i < 480; i++)
                       if (k < cnt && !md[i]) begin md[i] = 1; nm[i] = 1; k++; end
                1: for (int i = 0; i < 480; i++)
                       if (k < cnt && md[i]) begin md[i] = 0; nm[i] = 1; k++; end
                2: begin nm = msk & ~md; md = md | msk; if (slp) mc[0] = 1; end
                3: begin nm = msk & md; md = md & ~msk; if (slp) mc[0] = 1; end
                4: mc = mc | w;
                5: mc = mc & ~w;
                default: ;
            endcase
            mm = nm;
            mw = prev;
            mdead = prev[1];
            mtag = tag;
        end
        mrv = acc || (mrv && !rr);
        cur_rr = rr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 6, 0, '0, '0, 0, 1, "R11");
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit [479:0] m;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk(req_ready === 1'b1, "R1", "req_ready after reset", 480'(req_ready), 480'(1));
        chk(resp_valid === 1'b0, "R1", "resp_valid after reset", 480'(resp_valid), 480'(0));
        step(1, 6, 0, '0, '0, 0, 1, "R1");          // control word reads zero
        step(1, 1, 480, '0, '0, 0, 1, "R1");        // drain finds empty bitmap
        // R2 fill, then R11 back to back fill sees new state
        step(1, 0, 5, '0, '0, 0, 1, "R2");
        step(1, 0, 3, '0, '0, 0, 1, "R11");
        // R3 drain lowest set bits
        step(1, 1, 2, '0, '0, 0, 1, "R3");
        // R7 OR update with sleep, twice
        m = '0; m[100] = 1; m[3] = 1; m[479] = 1;
        step(1, 2, 0, m, '0, 1, 1, "R7");
        step(1, 2, 0, m | 480'hF0, '0, 1, 1, "R7");
        // R8 AND update then fill into freed holes
        m = '0; m[3] = 1; m[100] = 1; m[200] = 1;
        step(1, 3, 0, m, '0, 0, 1, "R8");
        step(1, 0, 4, '0, '0, 0, 1, "R2");
        // R5 zero limit and oversized limit
        step(1, 0, 0, '0, '0, 0, 1, "R5");
        step(1, 0, 500, '0, '0, 0, 1, "R5");
        // R4 full bitmap fill
        step(1, 0, 7, '0, '0, 0, 1, "R4");
        // R6 control word untouched by fill and drain
        step(1, 7, 0, '0, '0, 0, 1, "R6");
        // R10 and R9: set dead, pick ops report it
        step(1, 4, 0, '0, 32'h0000_0006, 0, 1, "R10");
        step(1, 1, 511, '0, '0, 0, 1, "R9");
        step(1, 1, 9, '0, '0, 0, 1, "R4");
        step(1, 5, 0, '0, 32'h0000_0003, 0, 1, "R10");
        step(1, 6, 0, '0, '0, 0, 1, "R10");
        // R12 backpressure: requests stall while response held
        step(1, 0, 10, '0, '0, 0, 0, "R12");
        step(1, 0, 20, '0, '0, 0, 0, "R12");
        step(1, 0, 20, '0, '0, 0, 0, "R12");
        step(1, 0, 20, '0, '0, 0, 1, "R12");
        idle(2);
        // mixed back to back traffic with random backpressure
        for (int i = 0; i < 3000; i++) begin
            int op;
            bit [479:0] rm;
            rm = {15{$urandom}} & {15{$urandom}} & {15{$urandom}};
            op = $urandom % 8;
            step(($urandom % 5) != 0, op, $urandom % 512, rm, $urandom & 32'h3,
                 $urandom % 2, ($urandom % 4) != 0, "R11");
        end
        idle(3);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule